// File: doc/BRIEF.md
# Shared RAM Autoincrement Access Port

This block gives a host processor byte-wide, indirect access to a RAM that it shares with a coprocessor. The host sees four byte registers: pointer low, pointer high, data, and control/status. It loads a 16-bit pointer with two byte writes. After that, every access to the data register reads or writes the RAM byte the pointer addresses. When autoincrement is enabled, the pointer advances after each data access. Code and tables can then be streamed into or out of the RAM through a single register, without reloading the address for each byte.

The control/status register carries three kinds of state:
- A run control for the coprocessor, kept in a two-state machine with the states HALTED and RUNNING.
- A strobe that raises a one-cycle interrupt toward the coprocessor.
- Two event flags (flag 0 and flag 1) that the coprocessor sets. The host acknowledges a flag by writing a 1 to its bit.

The two flags are ORed onto one host interrupt line. The coprocessor has its own synchronous port on the same RAM.

The run state machine has two transitions:
- GO: from HALTED to RUNNING, on a control write with the run bit set.
- STOP: from RUNNING to HALTED, on a control write with the run bit clear.

Any other cycle holds the current state.

Top module: `shram_port`

## Requirements
- R1: After reset the pointer is 0x0000, the state machine is HALTED, autoincrement is off, both flags are clear, and `host_irq`, `cop_run` and `cop_irq` are low.
- R2: A write to register 0 loads pointer bits 7:0, and a write to register 1 loads pointer bits 15:8. Reading register 0 or register 1 returns that pointer byte on `host_rdata` in the cycle after the read strobe.
- R3: A write to register 2 stores the byte at RAM index = pointer modulo 2^RAM_AW. A read of register 2 returns the byte at that index on `host_rdata` in the cycle after the strobe.
- R4: When control bit 1 (autoincrement) is set, each register-2 access adds one to the pointer, wrapping from 0xFFFF to 0x0000. When bit 1 is clear, the pointer is unchanged. Only accesses to registers 0 to 2 can change the pointer.
- R5: A write to register 3 takes the GO transition when bit 0 is 1 and the STOP transition when bit 0 is 0. `cop_run` is high in RUNNING from the cycle after the write, and it changes on no other event.
- R6: A register-3 write with bit 2 and bit 0 both set raises `cop_irq` for exactly one cycle, the cycle after the write. Bit 2 with bit 0 clear gives no pulse.
- R7: `cop_set_int0` sets flag 0 and `cop_set_int1` sets flag 1. These flags read back in register 3 as bit 4 and bit 5; bits 0 and 1 read back run and autoincrement, and the other bits read 0. A register-3 write with bit 4 or bit 5 set clears only that flag. A 0 in those bits leaves the flag as it is.
- R8: When the coprocessor sets a flag in the same cycle as a host clear of that flag, the flag ends up set.
- R9: `host_irq` is high exactly when flag 0 or flag 1 is set.
- R10: The coprocessor port writes the RAM when `cop_ram_we` is high. It returns the byte at `cop_ram_addr` on `cop_ram_rdata` one cycle later, with the value from before any write in that cycle. When both ports write the same index in the same cycle, the host byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host register access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_reg | input | 2 | Register select: 0 pointer low, 1 pointer high, 2 data, 3 control/status |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte, valid in the cycle after a read strobe |
| host_irq | output | 1 | Host interrupt, OR of the two flags |
| cop_run | output | 1 | Coprocessor run enable |
| cop_irq | output | 1 | One-cycle interrupt pulse to the coprocessor |
| cop_set_int0 | input | 1 | Coprocessor sets flag 0 |
| cop_set_int1 | input | 1 | Coprocessor sets flag 1 |
| cop_ram_addr | input | RAM_AW | Coprocessor RAM index |
| cop_ram_we | input | 1 | Coprocessor RAM write enable |
| cop_ram_wdata | input | 8 | Coprocessor RAM write byte |
| cop_ram_rdata | output | 8 | Coprocessor RAM read byte, one cycle latency |

## Verification
The bench drives the main function with three patterns:
- A burst of data writes with autoincrement on, read back as a stream. This separates pointer stepping from pointer holding.
- Repeated writes to a fixed pointer with autoincrement off. The last value must win and the pointer must stay put.
- A write at pointer 0xFFFF. This exposes a missing or wrong wrap.

Control writes cover every combination of the run and interrupt bits, which tells a held request apart from a pulse and a gated pulse from an ungated one. The flag patterns cover a single set, a clear of one flag while the other is set, and a set colliding with a clear. A simultaneous same-index write from both ports shows which port wins.

// File: rtl/shram_port_pkg.sv
package shram_port_pkg;

    localparam int BYTE_W = 8;

    // host register select codes
    localparam logic [1:0] REG_PTR_LO = 2'd0;
    localparam logic [1:0] REG_PTR_HI = 2'd1;
    localparam logic [1:0] REG_DATA   = 2'd2;
    localparam logic [1:0] REG_CTRL   = 2'd3;

    // control / status bit positions
    localparam int CB_RUN  = 0;
    localparam int CB_AINC = 1;
    localparam int CB_CIRQ = 2;
    localparam int CB_F0   = 4;
    localparam int CB_F1   = 5;

    localparam int NUM_FLAGS = 2;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

endpackage

// File: rtl/shram_ptr.sv
module shram_ptr #(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic             step,
    input  logic [7:0]       wbyte,
    output logic [PTR_W-1:0] ptr
);
    localparam int HI_W = PTR_W - 8;
    localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (ld_lo) begin
            ptr[7:0] <= wbyte;
        end else if (ld_hi) begin
            ptr[PTR_W-1:8] <= wbyte[HI_W-1:0];
        end else if (step) begin
            ptr <= ptr + ONE;
        end
    end

endmodule

// File: rtl/shram_ram.sv
module shram_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic [AW-1:0] a_addr,
    input  logic          a_we,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic [AW-1:0] b_addr,
    input  logic          b_we,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // read-before-write on both ports; port a (host) is written last and wins
    always_ff @(posedge clk) begin
        a_rdata <= mem[a_addr];
        b_rdata <= mem[b_addr];
        if (b_we) begin
            mem[b_addr] <= b_wdata;
        end
        if (a_we) begin
            mem[a_addr] <= a_wdata;
        end
    end

endmodule

// File: rtl/shram_ctrl.sv
module shram_ctrl
    import shram_port_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_wr,
    input  logic                 w_run,
    input  logic                 w_ainc,
    input  logic                 w_cirq,
    input  logic [NUM_FLAGS-1:0] w_clr,
    input  logic [NUM_FLAGS-1:0] set,
    output logic                 run,
    output logic                 ainc,
    output logic [NUM_FLAGS-1:0] flag,
    output logic                 cop_irq
);
    run_state_e state_q;
    run_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: GO and STOP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (ctrl_wr && w_run)  state_d = ST_RUN;
            ST_RUN:  if (ctrl_wr && !w_run) state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    // outputs
    always_comb begin
        run = (state_q == ST_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ainc    <= 1'b0;
            cop_irq <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ainc <= w_ainc;
            end
            cop_irq <= ctrl_wr && w_cirq && w_run;
        end
    end

    // event flags: set has priority over acknowledge
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag[g] <= 1'b0;
            end else if (set[g]) begin
                flag[g] <= 1'b1;
            end else if (ctrl_wr && w_clr[g]) begin
                flag[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/shram_port.sv
module shram_port
    import shram_port_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int RAM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_we,
    input  logic [1:0]        host_reg,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              host_irq,
    output logic              cop_run,
    output logic              cop_irq,
    input  logic              cop_set_int0,
    input  logic              cop_set_int1,
    input  logic [RAM_AW-1:0] cop_ram_addr,
    input  logic              cop_ram_we,
    input  logic [7:0]        cop_ram_wdata,
    output logic [7:0]        cop_ram_rdata
);
    logic              wr_lo, wr_hi, wr_data, rd_data, wr_ctrl;
    logic              ainc;
    logic              run;
    logic [NUM_FLAGS-1:0] flag;
    logic [PTR_W-1:0]  ptr_q;
    logic [7:0]        ram_rdata;
    logic [7:0]        status;
    logic [7:0]        reg_rdata_q;
    logic              rd_is_data_q;

    always_comb begin
        wr_lo   = host_sel && host_we && (host_reg == REG_PTR_LO);
        wr_hi   = host_sel && host_we && (host_reg == REG_PTR_HI);
        wr_data = host_sel && host_we && (host_reg == REG_DATA);
        rd_data = host_sel && !host_we && (host_reg == REG_DATA);
        wr_ctrl = host_sel && host_we && (host_reg == REG_CTRL);
    end

    shram_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_lo (wr_lo),
        .ld_hi (wr_hi),
        .step  ((wr_data || rd_data) && ainc),
        .wbyte (host_wdata),
        .ptr   (ptr_q)
    );

    shram_ram #(.AW(RAM_AW), .DW(BYTE_W)) u_ram (
        .clk     (clk),
        .a_addr  (ptr_q[RAM_AW-1:0]),
        .a_we    (wr_data),
        .a_wdata (host_wdata),
        .a_rdata (ram_rdata),
        .b_addr  (cop_ram_addr),
        .b_we    (cop_ram_we),
        .b_wdata (cop_ram_wdata),
        .b_rdata (cop_ram_rdata)
    );

    shram_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (wr_ctrl),
        .w_run   (host_wdata[CB_RUN]),
        .w_ainc  (host_wdata[CB_AINC]),
        .w_cirq  (host_wdata[CB_CIRQ]),
        .w_clr   ({host_wdata[CB_F1], host_wdata[CB_F0]}),
        .set     ({cop_set_int1, cop_set_int0}),
        .run     (run),
        .ainc    (ainc),
        .flag    (flag),
        .cop_irq (cop_irq)
    );

    always_comb begin
        status          = '0;
        status[CB_RUN]  = run;
        status[CB_AINC] = ainc;
        status[CB_F0]   = flag[0];
        status[CB_F1]   = flag[1];
    end

    // register readback, one cycle after the strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata_q  <= '0;
            rd_is_data_q <= 1'b0;
        end else begin
            rd_is_data_q <= rd_data;
            if (host_sel && !host_we) begin
                unique case (host_reg)
                    REG_PTR_LO: reg_rdata_q <= ptr_q[7:0];
                    REG_PTR_HI: reg_rdata_q <= 8'(ptr_q[PTR_W-1:8]);
                    REG_CTRL:   reg_rdata_q <= status;
                    default:    reg_rdata_q <= '0;
                endcase
            end
        end
    end

    assign host_rdata = rd_is_data_q ? ram_rdata : reg_rdata_q;
    assign host_irq   = |flag;
    assign cop_run    = run;

endmodule

// File: rtl/shram_port_chk.sv
module shram_port_chk
    import shram_port_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_sel,
    input logic             host_we,
    input logic [1:0]       host_reg,
    input logic [7:0]       host_wdata,
    input logic             cop_set_int0,
    input logic             cop_set_int1,
    input logic             cop_irq,
    input logic             cop_run,
    input logic             host_irq,
    input logic [PTR_W-1:0] ptr
);
    logic ctrl_wr;
    assign ctrl_wr = host_sel && host_we && (host_reg == REG_CTRL);

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cop_irq |=> !cop_irq); // R6

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cop_irq |-> $past(ctrl_wr && host_wdata[CB_CIRQ] && host_wdata[CB_RUN])); // R6

    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ctrl_wr) |-> $stable(cop_run)); // R5

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!(host_sel && (host_reg != REG_CTRL)))) |-> $stable(ptr)); // R4

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cop_set_int0 || cop_set_int1)) |-> host_irq); // R8

    AST_ACK_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ctrl_wr && host_wdata[CB_F0] && host_wdata[CB_F1])
         && $past(!cop_set_int0 && !cop_set_int1)) |-> !host_irq); // R7

endmodule

bind shram_port shram_port_chk #(.PTR_W(PTR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_sel     (host_sel),
    .host_we      (host_we),
    .host_reg     (host_reg),
    .host_wdata   (host_wdata),
    .cop_set_int0 (cop_set_int0),
    .cop_set_int1 (cop_set_int1),
    .cop_irq      (cop_irq),
    .cop_run      (cop_run),
    .host_irq     (host_irq),
    .ptr          (ptr_q)
);

// File: tb/shram_port_tb.sv
`timescale 1ns/1ps
module shram_port_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 1'b0;
    logic       host_we = 1'b0;
    logic [1:0] host_reg = 2'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       host_irq, cop_run, cop_irq;
    logic       cop_set_int0 = 1'b0;
    logic       cop_set_int1 = 1'b0;
    logic [7:0] cop_ram_addr = 8'd0;
    logic       cop_ram_we = 1'b0;
    logic [7:0] cop_ram_wdata = 8'd0;
    logic [7:0] cop_ram_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_tag = "R3";

    always #10 clk = ~clk;

    shram_port u_dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
        .host_reg(host_reg), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_irq(host_irq), .cop_run(cop_run), .cop_irq(cop_irq),
        .cop_set_int0(cop_set_int0), .cop_set_int1(cop_set_int1),
        .cop_ram_addr(cop_ram_addr), .cop_ram_we(cop_ram_we),
        .cop_ram_wdata(cop_ram_wdata), .cop_ram_rdata(cop_ram_rdata)
    );

    // ---------------- behavioural reference model ----------------
    int         m_ptr = 0;
    bit         m_run = 0, m_ainc = 0, m_f0 = 0, m_f1 = 0, m_cirq = 0;
    logic [7:0] m_mem [int];
    bit         rd_pend = 0;
    logic [7:0] rd_exp = 0;
    string      rd_tag = "";
    bit         cp_pend = 0;
    logic [7:0] cp_exp = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ptr = 0; m_run = 0; m_ainc = 0; m_f0 = 0; m_f1 = 0; m_cirq = 0;
            rd_pend = 0; cp_pend = 0;
        end else begin
            bit is_ctrl_wr;
            int idx;
            idx = m_ptr % 256;
            is_ctrl_wr = host_sel && host_we && host_reg == 2'd3;
            // reads see the state before this edge
            rd_pend = host_sel && !host_we;
            rd_tag  = cur_tag;
            if (rd_pend) begin
                case (host_reg)
                    2'd0: rd_exp = 8'(m_ptr % 256);
                    2'd1: rd_exp = 8'(m_ptr / 256);
                    2'd2: begin
                        if (m_mem.exists(idx)) rd_exp = m_mem[idx];
                        else rd_pend = 0;
                    end
                    default: rd_exp = {2'b00, m_f1, m_f0, 2'b00, m_ainc, m_run};
                endcase
            end
            cp_pend = m_mem.exists(int'(cop_ram_addr));
            if (cp_pend) cp_exp = m_mem[int'(cop_ram_addr)];
            m_cirq = is_ctrl_wr && host_wdata[2] && host_wdata[0];
            if (is_ctrl_wr && host_wdata[4]) m_f0 = 0;
            if (is_ctrl_wr && host_wdata[5]) m_f1 = 0;
            if (cop_set_int0) m_f0 = 1;
            if (cop_set_int1) m_f1 = 1;
            if (is_ctrl_wr) begin
                m_run  = host_wdata[0];
                m_ainc = host_wdata[1];
            end
            if (cop_ram_we) m_mem[int'(cop_ram_addr)] = cop_ram_wdata;
            if (host_sel && host_we && host_reg == 2'd2) m_mem[idx] = host_wdata;
            if (host_sel && host_we && host_reg == 2'd0)
                m_ptr = (m_ptr / 256) * 256 + int'(host_wdata);
            else if (host_sel && host_we && host_reg == 2'd1)
                m_ptr = int'(host_wdata) * 256 + (m_ptr % 256);
            else if (host_sel && host_reg == 2'd2 && m_ainc)
                m_ptr = (m_ptr + 1) % 65536;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cop_run == m_run,   "R5", int'(cop_run),  int'(m_run));
            chk(cop_irq == m_cirq,  "R6", int'(cop_irq),  int'(m_cirq));
            chk(host_irq == (m_f0 | m_f1), "R9", int'(host_irq), int'(m_f0 | m_f1));
            if (rd_pend) chk(host_rdata == rd_exp, rd_tag, int'(host_rdata), int'(rd_exp));
            if (cp_pend) chk(cop_ram_rdata == cp_exp, "R10", int'(cop_ram_rdata), int'(cp_exp));
        end
    end

    // ---------------- stimulus ----------------
    task automatic drive(input bit s, input bit w, input logic [1:0] r, input logic [7:0] d,
                         input string tag);
        @(negedge clk); #1;
        host_sel = s; host_we = w; host_reg = r; host_wdata = d; cur_tag = tag;
        cop_set_int0 = 0; cop_set_int1 = 0; cop_ram_we = 0;
    endtask

    task automatic hw(input logic [1:0] r, input logic [7:0] d);
        drive(1, 1, r, d, "R2");
    endtask

    task automatic hr(input logic [1:0] r, input string tag);
        drive(1, 0, r, 8'h00, tag);
    endtask

    task automatic idle();
        drive(0, 0, 2'd0, 8'h00, "R3");
    endtask

    task automatic cop_set(input bit s0, input bit s1);
        drive(0, 0, 2'd0, 8'h00, "R7");
        cop_set_int0 = s0; cop_set_int1 = s1;
    endtask

    task automatic cop_wr(input logic [7:0] a, input logic [7:0] d);
        drive(0, 0, 2'd0, 8'h00, "R10");
        cop_ram_addr = a; cop_ram_we = 1; cop_ram_wdata = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        // R1: reset values through the register interface
        hr(2'd0, "R1"); hr(2'd1, "R1"); hr(2'd3, "R1");
        // R2: pointer load and readback
        hw(2'd0, 8'h34); hw(2'd1, 8'h12);
        hr(2'd0, "R2"); hr(2'd1, "R2");
        // R3/R4: streamed write with autoincrement
        hw(2'd3, 8'h02);
        hw(2'd2, 8'hA0); hw(2'd2, 8'hA1); hw(2'd2, 8'hA2); hw(2'd2, 8'hA3);
        hr(2'd0, "R4");
        hw(2'd0, 8'h34);
        hr(2'd2, "R3"); hr(2'd2, "R3"); hr(2'd2, "R3"); hr(2'd2, "R3");
        hr(2'd0, "R4");
        // R4: fixed pointer, autoincrement off
        hw(2'd3, 8'h00); hw(2'd0, 8'h50);
        hw(2'd2, 8'h77); hw(2'd2, 8'h78);
        hr(2'd2, "R3"); hr(2'd0, "R4");
        // R4: wrap at 0xFFFF
        hw(2'd3, 8'h02); hw(2'd0, 8'hFF); hw(2'd1, 8'hFF);
        hw(2'd2, 8'h5A);
        hr(2'd0, "R4"); hr(2'd1, "R4");
        // R5: run and halt
        hw(2'd3, 8'h03); idle(); idle();
        hw(2'd3, 8'h02); idle();
        hw(2'd3, 8'h03); hr(2'd3, "R5");
        // R6: interrupt pulse, gated by run
        hw(2'd3, 8'h07); idle(); idle();
        hw(2'd3, 8'h06); idle();
        hw(2'd3, 8'h03);
        // R7: flags set and acknowledged one at a time
        cop_set(1, 0); hr(2'd3, "R7");
        cop_set(0, 1); hr(2'd3, "R7");
        hw(2'd3, 8'h13); hr(2'd3, "R7");
        hw(2'd3, 8'h23); hr(2'd3, "R7");
        hw(2'd3, 8'h33); hr(2'd3, "R7");
        // R8: set collides with acknowledge
        hw(2'd3, 8'h13); cop_set_int0 = 1;
        hr(2'd3, "R8");
        hw(2'd3, 8'h13); hr(2'd3, "R8");
        // R10: coprocessor port
        cop_wr(8'h40, 8'hC3);
        hw(2'd1, 8'h00); hw(2'd0, 8'h40);
        hr(2'd2, "R10");
        idle(); cop_ram_addr = 8'hFF; idle();
        hw(2'd0, 8'h41);
        hw(2'd2, 8'h11); cop_ram_addr = 8'h41; cop_ram_we = 1; cop_ram_wdata = 8'h22;
        idle(); cop_ram_addr = 8'h41; idle(); idle();
        hw(2'd0, 8'h41); hr(2'd2, "R10");
        idle(); idle();
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule